// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Pixel Stream Buffer

This block stages frame data between a processor register bus and a display pixel consumer. The storage is a two-bank dual-port RAM. Software writes one batch of pixel words, word by word, into the back bank through memory-mapped writes on the bus clock. Meanwhile the display side reads the front bank in sequence on its own pixel clock.

When a batch is complete, software raises a load command in the control register. The command crosses into the pixel domain as a toggle. The display side moves to the freshly written bank only when its read address wraps, so a displayed batch is never a mix of old and new data. A test-mode bit in the same register replaces the stored pixels with colour bars computed from the read address. RAM writes continue unchanged while test mode is on.

Top module: `pixel_stream_buffer`

## Requirements
- R1: While reset is asserted and directly after it is released, `pix_valid` is 0 and `pix_rgb` is 0. The display side reads bank 0 and bus writes fill bank 1.
- R2: A bus write to byte address 0x10 + 4*i, with i from 0 to 1023, stores the word in entry i of the write bank. Writes to unaligned addresses, to addresses at or above 0x1010, and to any address from 0x1 to 0xF other than 0x0 change nothing.
- R3: A bus write to address 0x0 replaces the control bits with `bus_wdata[1:0]`. Bit 0 enables test mode and bit 1 is the load request. Writing 0 clears both bits.
- R4: A bank swap is requested only when a control write takes bit 1 from 0 to 1. A further write that keeps bit 1 at 1 requests nothing.
- R5: Each cycle with `pix_en` high reads one word at the current read address, and the address then advances by one, wrapping from 1023 to 0. The word appears on `pix_rgb` with `pix_valid` high one pixel clock later. `pix_valid` is low one cycle after a cycle with `pix_en` low.
- R6: The display bank changes only on the read-address wrap that follows a swap request. A request made mid-batch leaves the rest of that batch intact.
- R7: Bus writes go to the write bank. The write bank starts as bank 1 and flips on every swap request, so it is the bank that the display will not be reading once the pending swap is done.
- R8: `pix_rgb` carries bits 23:0 of the stored word: red 23:16, green 15:8, blue 7:0. Bits 31:24 are discarded.
- R9: In test mode `pix_rgb` shows colour bar b = read address bits 9:7. Red is FF if b[2] is set, green is FF if b[1] is set, blue is FF if b[0] is set, and each channel is 00 otherwise. RAM writes and bank swaps behave as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-side clock |
| clk_pix | input | 1 | Pixel-side clock, independent of clk_bus |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 13 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| pix_en | input | 1 | Consume one pixel this cycle |
| pix_valid | output | 1 | pix_rgb holds a freshly read pixel |
| pix_rgb | output | 24 | Pixel as red, green, blue bytes |

## Verification
The bench issues a swap request halfway through a displayed batch and checks that the remaining 512 words still come from the old bank. A design that swapped on arrival of the request would tear the image at word 512. It repeats a load write without clearing it first; a level-triggered design would swap a second time and show the wrong batch. It places writes just past the last word, on unaligned addresses and on the control gap with the load bit set; poor decode would corrupt word 0 or trigger a stray swap. It also fills a bank while test mode is active, then checks that bank after test mode is cleared, which exposes a design that gates writes in test mode.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int unsigned CTRL_OFS = 'h0;
  localparam int unsigned DATA_OFS = 'h10;
  localparam int unsigned TEST_BIT = 0;
  localparam int unsigned LOAD_BIT = 1;
  localparam int unsigned CH_W     = 8;
  localparam int unsigned PIX_W    = 3 * CH_W;
endpackage

// File: rtl/psb_rstsync.sv
module psb_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n = sh_q[1];
endmodule

// File: rtl/psb_regif.sv
module psb_regif import psb_pkg::*; #(
  parameter int unsigned BUS_AW  = 13,
  parameter int unsigned WORD_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               ram_we,
  output logic [WORD_AW:0]   ram_waddr,
  output logic [PIX_W-1:0]   ram_wdata,
  output logic               test_en,
  output logic               swap_tog,
  output logic               wr_bank,
  output logic               load_q
);
  localparam int unsigned NWORDS = 1 << WORD_AW;
  localparam logic [BUS_AW:0] LO_A = (BUS_AW+1)'(DATA_OFS);
  localparam logic [BUS_AW:0] HI_A = (BUS_AW+1)'(DATA_OFS + 4 * NWORDS);
  localparam logic [BUS_AW:0] CT_A = (BUS_AW+1)'(CTRL_OFS);

  logic [BUS_AW:0] addr_x, off;
  logic            ctrl_hit, data_hit, load_rise;
  logic [1:0]      ctrl_q, ctrl_d;
  logic            tog_q, tog_d, bank_q, bank_d;
  logic            unused_bits;

  always_comb begin
    addr_x    = {1'b0, bus_addr};
    off       = addr_x - LO_A;
    ctrl_hit  = bus_we && (addr_x == CT_A);
    data_hit  = bus_we && (addr_x >= LO_A) && (addr_x < HI_A) && (bus_addr[1:0] == 2'b00);
    load_rise = ctrl_hit && bus_wdata[LOAD_BIT] && !ctrl_q[LOAD_BIT];
    ctrl_d    = ctrl_hit ? bus_wdata[1:0] : ctrl_q;
    tog_d     = tog_q ^ load_rise;
    bank_d    = bank_q ^ load_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 2'b00;
      tog_q  <= 1'b0;
      bank_q <= 1'b1;
    end else begin
      ctrl_q <= ctrl_d;
      tog_q  <= tog_d;
      bank_q <= bank_d;
    end
  end

  assign ram_we      = data_hit;
  assign ram_waddr   = {bank_q, off[WORD_AW+1:2]};
  assign ram_wdata   = bus_wdata[PIX_W-1:0];
  assign test_en     = ctrl_q[TEST_BIT];
  assign load_q      = ctrl_q[LOAD_BIT];
  assign swap_tog    = tog_q;
  assign wr_bank     = bank_q;
  assign unused_bits = ^{off[1:0], off[BUS_AW:WORD_AW+2], bus_wdata[31:PIX_W]};
endmodule

// File: rtl/psb_dpram.sv
module psb_dpram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 24
) (
  input  logic          clk_w,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          clk_r,
  input  logic          rst_r_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_w) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk_r or negedge rst_r_n) begin
    if (!rst_r_n) rdata <= '0;
    else if (re)  rdata <= mem[raddr];
  end
endmodule

// File: rtl/psb_reader.sv
module psb_reader import psb_pkg::*; #(
  parameter int unsigned WORD_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               swap_tog,
  input  logic               test_in,
  input  logic               pix_en,
  output logic [WORD_AW-1:0] rd_addr,
  output logic               rd_bank,
  output logic               test_q,
  output logic               pix_valid,
  output logic [PIX_W-1:0]   pat_q
);
  localparam logic [WORD_AW-1:0] LAST = '1;

  logic [2:0]         tog_s;
  logic [1:0]         tst_s;
  logic               evt, wrap, pend_q, pend_d, bank_d, vld_d;
  logic [WORD_AW-1:0] addr_d;
  logic [2:0]         bar;
  logic [PIX_W-1:0]   pat_d;

  always_comb begin
    evt    = tog_s[2] ^ tog_s[1];
    wrap   = pix_en && (rd_addr == LAST);
    pend_d = wrap ? 1'b0 : (pend_q | evt);
    bank_d = rd_bank ^ (wrap && (pend_q || evt));
    addr_d = pix_en ? rd_addr + 1'b1 : rd_addr;
    vld_d  = pix_en;
    bar    = rd_addr[WORD_AW-1 -: 3];
    pat_d  = pix_en ? {{CH_W{bar[2]}}, {CH_W{bar[1]}}, {CH_W{bar[0]}}} : pat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_s     <= '0;
      tst_s     <= '0;
      pend_q    <= 1'b0;
      rd_bank   <= 1'b0;
      rd_addr   <= '0;
      pix_valid <= 1'b0;
      pat_q     <= '0;
    end else begin
      tog_s     <= {tog_s[1:0], swap_tog};
      tst_s     <= {tst_s[0], test_in};
      pend_q    <= pend_d;
      rd_bank   <= bank_d;
      rd_addr   <= addr_d;
      pix_valid <= vld_d;
      pat_q     <= pat_d;
    end
  end

  assign test_q = tst_s[1];
endmodule

// File: rtl/pixel_stream_buffer.sv
module pixel_stream_buffer import psb_pkg::*; #(
  parameter int unsigned BUS_AW  = 13,
  parameter int unsigned WORD_AW = 10
) (
  input  logic              clk_bus,
  input  logic              clk_pix,
  input  logic              arst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              pix_en,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_rgb
);
  logic               rst_bus_n, rst_pix_n;
  logic               ram_we, test_en, swap_tog, wr_bank, load_q;
  logic [WORD_AW:0]   ram_waddr;
  logic [PIX_W-1:0]   ram_wdata, ram_rdata, pat_q;
  logic [WORD_AW-1:0] rd_addr;
  logic               rd_bank, test_q;

  psb_rstsync u_rs_bus (.clk(clk_bus), .arst_n(arst_n), .rst_n(rst_bus_n));
  psb_rstsync u_rs_pix (.clk(clk_pix), .arst_n(arst_n), .rst_n(rst_pix_n));

  psb_regif #(.BUS_AW(BUS_AW), .WORD_AW(WORD_AW)) u_regif (
    .clk(clk_bus), .rst_n(rst_bus_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .test_en(test_en), .swap_tog(swap_tog),
    .wr_bank(wr_bank), .load_q(load_q)
  );

  psb_dpram #(.AW(WORD_AW + 1), .DW(PIX_W)) u_ram (
    .clk_w(clk_bus), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .clk_r(clk_pix), .rst_r_n(rst_pix_n), .re(pix_en),
    .raddr({rd_bank, rd_addr}), .rdata(ram_rdata)
  );

  psb_reader #(.WORD_AW(WORD_AW)) u_reader (
    .clk(clk_pix), .rst_n(rst_pix_n), .swap_tog(swap_tog), .test_in(test_en),
    .pix_en(pix_en), .rd_addr(rd_addr), .rd_bank(rd_bank), .test_q(test_q),
    .pix_valid(pix_valid), .pat_q(pat_q)
  );

  assign pix_rgb = test_q ? pat_q : ram_rdata;
endmodule

// File: rtl/psb_chk.sv
module psb_chk #(
  parameter int unsigned BUS_AW  = 13,
  parameter int unsigned WORD_AW = 10
) (
  input logic               clk_bus,
  input logic               rst_bus_n,
  input logic               clk_pix,
  input logic               rst_pix_n,
  input logic               bus_we,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               load_q,
  input logic               wr_bank,
  input logic               pix_en,
  input logic               pix_valid,
  input logic [23:0]        pix_rgb,
  input logic [WORD_AW-1:0] rd_addr,
  input logic               rd_bank,
  input logic               test_q
);
  localparam logic [WORD_AW-1:0] LAST = '1;

  // R5
  valid_follow_chk: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    pix_en |=> pix_valid);
  // R5
  valid_drop_chk: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    !pix_en |=> !pix_valid);
  // R5
  addr_wrap_chk: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    (pix_en && rd_addr == LAST) |=> (rd_addr == '0));
  // R5
  addr_hold_chk: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    !pix_en |=> $stable(rd_addr));
  // R6
  bank_at_wrap_chk: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    !(pix_en && rd_addr == LAST) |=> $stable(rd_bank));
  // R4
  swap_on_rise_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (bus_we && bus_addr == '0 && bus_wdata[1] && !load_q) |=> (wr_bank != $past(wr_bank)));
  // R4
  no_stray_swap_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    !(bus_we && bus_addr == '0 && bus_wdata[1] && !load_q) |=> $stable(wr_bank));
  // R9
  test_colour_chk: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    (pix_valid && test_q) |-> ((pix_rgb[23:16] == 8'h00 || pix_rgb[23:16] == 8'hFF) &&
                               (pix_rgb[15:8]  == 8'h00 || pix_rgb[15:8]  == 8'hFF) &&
                               (pix_rgb[7:0]   == 8'h00 || pix_rgb[7:0]   == 8'hFF)));
endmodule

bind pixel_stream_buffer psb_chk #(.BUS_AW(BUS_AW), .WORD_AW(WORD_AW)) u_chk (
  .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_pix(clk_pix), .rst_pix_n(rst_pix_n),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .load_q(load_q),
  .wr_bank(wr_bank), .pix_en(pix_en), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
  .rd_addr(rd_addr), .rd_bank(rd_bank), .test_q(test_q)
);

// File: tb/tb_pixel_stream_buffer.sv
module tb_pixel_stream_buffer;
  logic        clk_bus = 1'b0, clk_pix = 1'b0, arst_n = 1'b0;
  logic        bus_we = 1'b0, pix_en = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        pix_valid;
  logic [23:0] pix_rgb;
  int          n_run = 0, n_fail = 0;

  always #10 clk_bus = ~clk_bus;
  always #13 clk_pix = ~clk_pix;

  pixel_stream_buffer dut (
    .clk_bus(clk_bus), .clk_pix(clk_pix), .arst_n(arst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pix_en(pix_en),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb)
  );

  // {word index, data} overrides for batch A
  localparam logic [41:0] VEC [8] = '{
    {10'd0,    32'hFF00_0000}, {10'd1,    32'h12AB_CDEF},
    {10'd127,  32'h8001_0203}, {10'd128,  32'h00FF_FFFF},
    {10'd511,  32'h7777_7777}, {10'd512,  32'hA5C3_3C5A},
    {10'd1022, 32'h0102_0304}, {10'd1023, 32'hFEDC_BA98}
  };

  function automatic logic [31:0] word_of(int kind, int i);
    logic [9:0] w = 10'(i);
    case (kind)
      0: begin
        for (int k = 0; k < 8; k++)
          if (VEC[k][41:32] == w) return VEC[k][31:0];
        return {8'h5A, w[7:0], ~w[7:0], w[9:2]};
      end
      1: return {8'hC3, w[9:2] ^ 8'h3C, w[7:0], 8'h81};
      default: return {8'h3E, 8'h11, w[9:2], ~w[7:0]};
    endcase
  endfunction

  function automatic logic [23:0] exp_pix(int kind, int i);
    logic [9:0] w = 10'(i);
    if (kind == 3)
      return {{8{w[9]}}, {8{w[8]}}, {8{w[7]}}};
    return word_of(kind, i) & 32'h00FF_FFFF;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_we = 1'b0;
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < 1024; i++) bus_wr(13'(16 + 4 * i), word_of(kind, i));
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_pix);
  endtask

  // kind <0: consume without checking
  task automatic read_words(input int kind, input int start, input int count, input string tag);
    @(negedge clk_pix);
    pix_en = 1'b1;
    for (int i = start; i < start + count; i++) begin
      @(negedge clk_pix);
      if (i == start + count - 1) pix_en = 1'b0;
      if (kind >= 0) begin
        check(pix_valid && pix_rgb == exp_pix(kind, i), tag, {7'd0, pix_valid, pix_rgb},
              {8'h01, exp_pix(kind, i)});
      end
    end
    @(negedge clk_pix);
    check(!pix_valid, "R5 valid low after idle", {31'd0, pix_valid}, 32'd0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_pix);
    check(!pix_valid && pix_rgb == 24'd0, "R1 in reset", {7'd0, pix_valid, pix_rgb}, 32'd0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk_bus);
    check(!pix_valid && pix_rgb == 24'd0, "R1 after release", {7'd0, pix_valid, pix_rgb}, 32'd0);

    // R2 R8: batch A into bank 1, then decode-edge writes that must do nothing
    fill(0);
    bus_wr(13'h1010, 32'hFFFF_FFFF);
    bus_wr(13'h0012, 32'hDEAD_BEEF);
    bus_wr(13'h0004, 32'h0000_0002);
    bus_wr(13'h0008, 32'h0000_0003);
    bus_wr(13'h0000, 32'h2);
    bus_wr(13'h0000, 32'h0);
    settle();
    read_words(-1, 0, 1024, "");
    read_words(0, 0, 512, "R2 R8 batch A first half");

    // R6: swap requested mid-batch, R7 writes target bank 0
    fill(1);
    bus_wr(13'h0000, 32'h2);
    bus_wr(13'h0000, 32'h0);
    settle();
    read_words(0, 512, 512, "R6 no tear, batch A second half");
    read_words(1, 0, 1024, "R7 batch B after swap");

    // R4: level held high gives a single swap only
    bus_wr(13'h0000, 32'h2);
    bus_wr(13'h0000, 32'h2);
    settle();
    read_words(1, 0, 1024, "R4 batch B until wrap");
    read_words(0, 0, 1024, "R4 batch A after one swap");
    read_words(0, 0, 1024, "R4 no second swap");
    bus_wr(13'h0000, 32'h0);

    // R9 R3: test mode with writes and swap running underneath
    bus_wr(13'h0000, 32'h1);
    settle();
    fill(2);
    bus_wr(13'h0000, 32'h3);
    bus_wr(13'h0000, 32'h1);
    settle();
    read_words(3, 0, 1024, "R9 colour bars");
    bus_wr(13'h0000, 32'h0);
    settle();
    read_words(2, 0, 1024, "R9 R3 batch C written during test mode");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule